// File: doc/BRIEF.md
# Variable-Length SPI Writer With Trailing Clock

This block serializes one control word of 1 to 32 bits onto a write-only SPI-style port of the kind found on audio codecs. The host places a data word, a bit count and a one-hot choice of target on its inputs and pulses `start`. The block then drops the chosen active-low select line and forces the read/write line to the write level. It clocks the bits out most significant first and releases the select line. It then issues one more SCLK rising edge while no target is selected.

Every pin phase lasts a fixed number of clock cycles, set by the parameter `DLY_CYC`. That parameter is the delay unit, about 1 µs at the system clock. Requests with a zero or oversize count, or a select vector that is not one-hot, are dropped and cause no pin activity. Between transfers SCLK rests high, every select is high and MOSI keeps the last bit it sent.

Top module: `spi_tail_writer`

## Requirements
- R1: After reset, every `cs_n` line is 1, `sclk` is 1, `mosi` is 0, `rw_sel` is 0, and `busy` and `done` are 0.
- R2: A request is accepted when the block is idle, `start` is 1, `nbits` is between 1 and DATA_W, and `cs_sel` has exactly one bit set. In the next cycle `busy` is 1, `rw_sel` is 1, and the `cs_n` line whose index matches the set bit of `cs_sel` is 0 while every other line stays 1.
- R3: The first falling edge of `sclk` comes exactly DLY_CYC cycles after the select line falls.
- R4: Exactly `nbits` rising edges of `sclk` occur while the select is low. At those edges `mosi` carries `data[nbits-1]` down to `data[0]`, in that order.
- R5: `mosi` changes DLY_CYC cycles after each `sclk` fall. `sclk` rises DLY_CYC cycles after that. Each low phase therefore lasts 2·DLY_CYC cycles and each high phase between bits lasts DLY_CYC cycles.
- R6: After the last bit's high phase, `sclk` falls and the select line rises in the same cycle.
- R7: DLY_CYC cycles after the select rises, `sclk` rises once more while every select stays high.
- R8: DLY_CYC cycles after that trailing rise, `done` is 1 for exactly one cycle and `busy` falls in that same cycle. `busy` is high for 3·DLY_CYC·(nbits+1) cycles in total.
- R9: A `start` with `nbits` of 0 or above DATA_W, or with `cs_sel` not one-hot, is ignored: `busy`, `sclk`, `mosi` and `cs_n` do not change.
- R10: A `start` that arrives while `busy` is 1 is ignored. The running transfer is unchanged and no second transfer follows it.
- R11: While idle, `sclk` is 1, every `cs_n` line is 1, `mosi` holds the last bit sent, and `rw_sel` stays 1 once any transfer has run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| data | input | DATA_W | Word to send, right-aligned |
| nbits | input | $clog2(DATA_W+1) | Number of bits to send |
| cs_sel | input | CS_N | One-hot choice of target select line |
| busy | output | 1 | High from acceptance through the trailing edge |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | CS_N | Active-low select lines |
| rw_sel | output | 1 | Read/write line, driven to the write level (1) |
| mosi | output | 1 | Serial data out |
| sclk | output | 1 | Serial clock, rests high |

## Verification
Two cases are hardest to reach from the ports. One is a second `start` landing in the middle of a transfer. The other is the set of malformed requests that must leave every pin quiet. The driver raises `start` again with a different word several cycles into a 20-bit transfer. The scoreboard then requires exactly one completed item, carrying the original word.

The rejected requests (zero count, count 33, two-hot and empty select) are issued from idle. After each one the pins are watched over several delay units. The count extremes of 1 and 32 bits are also run, so the index's first and last values are both reached.

// File: rtl/spi_tail_pkg.sv
package spi_tail_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_DATA,
    ST_HIGH,
    ST_END,
    ST_TAIL
  } wr_state_t;

  // request count must lie inside 1..lim
  function automatic logic count_ok(int n, int lim);
    return (n >= 1) && (n <= lim);
  endfunction

  // exactly one bit set (select vectors are at most 32 wide)
  function automatic logic sel_onehot(logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  // busy length: setup + three phases per bit + release + tail
  function automatic int xfer_cycles(int n, int dly);
    return 3 * dly * (n + 1);
  endfunction

endpackage

// File: rtl/spi_tail_timer.sv
module spi_tail_timer #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load_i)          cnt <= CW'(DLY - 1);
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign expire_o = (cnt == '0);

endmodule

// File: rtl/spi_tail_csdrv.sv
module spi_tail_csdrv #(
  parameter int CS_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [CS_N-1:0] sel_i,
  output logic [CS_N-1:0] cs_n_o
);
  for (genvar g = 0; g < CS_N; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cs_n_o[g] <= 1'b1;
      else if (set_i && sel_i[g])  cs_n_o[g] <= 1'b0;
      else if (clr_i)              cs_n_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_tail_writer.sv
module spi_tail_writer
  import spi_tail_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CS_N    = 4,
  parameter int DLY_CYC = 8,
  localparam int CNT_W  = $clog2(DATA_W + 1),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  nbits,
  input  logic [CS_N-1:0]   cs_sel,
  output logic              busy,
  output logic              done,
  output logic [CS_N-1:0]   cs_n,
  output logic              rw_sel,
  output logic              mosi,
  output logic              sclk
);

  wr_state_t         state;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  n_q;

  // named internal events
  logic req_valid;   // request well-formed
  logic go;          // request accepted this cycle
  logic tick;        // current phase has lasted DLY_CYC cycles
  logic cs_release;  // last bit finished, select goes high
  logic last_bit;

  assign req_valid  = count_ok(int'(nbits), DATA_W) && sel_onehot(32'(cs_sel));
  assign go         = start && (state == ST_IDLE) && req_valid;
  assign last_bit   = (idx == '0);
  assign cs_release = (state == ST_HIGH) && tick && last_bit;
  assign busy       = (state != ST_IDLE);

  spi_tail_timer #(.DLY(DLY_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (go || (busy && tick)),
    .expire_o (tick)
  );

  spi_tail_csdrv #(.CS_N(CS_N)) u_cs (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (go),
    .clr_i  (cs_release),
    .sel_i  (cs_sel),
    .cs_n_o (cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= '0;
      idx    <= '0;
      n_q    <= '0;
      sclk   <= 1'b1;
      mosi   <= 1'b0;
      rw_sel <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (go) begin
          data_q <= data;
          idx    <= IDX_W'(nbits - 1'b1);
          n_q    <= nbits;
          rw_sel <= 1'b1;
          state  <= ST_SETUP;
        end
      end else if (tick) begin
        case (state)
          ST_SETUP: begin sclk <= 1'b0; state <= ST_LOW; end
          ST_LOW:   begin mosi <= data_q[idx]; state <= ST_DATA; end
          ST_DATA:  begin sclk <= 1'b1; state <= ST_HIGH; end
          ST_HIGH: begin
            sclk <= 1'b0;
            if (last_bit) state <= ST_END;
            else begin
              idx   <= idx - 1'b1;
              state <= ST_LOW;
            end
          end
          ST_END:   begin sclk <= 1'b1; state <= ST_TAIL; end
          ST_TAIL:  begin done <= 1'b1; state <= ST_IDLE; end
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  // busy-length counter kept for the length check below
  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (go)   busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
  end

  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R2
  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && (&cs_n))); // R11
  AST_RELEASE_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&cs_n) |-> $fell(sclk)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && busy_len == xfer_cycles(int'(n_q), DLY_CYC))); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !req_valid) |=> (!busy && $stable(cs_n) && $stable(sclk))); // R9
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(mosi)); // R11

endmodule

// File: tb/spi_tail_writer_test.sv
module spi_tail_writer_test;
  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int CSN   = 4;
  localparam int D     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] data = '0;
  logic [5:0] nbits = '0;
  logic [CSN-1:0] cs_sel = '0;
  logic busy, done, rw_sel, mosi, sclk;
  logic [CSN-1:0] cs_n;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_tail_writer #(.DATA_W(DW), .CS_N(CSN), .DLY_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .data(data), .nbits(nbits),
    .cs_sel(cs_sel), .busy(busy), .done(done), .cs_n(cs_n),
    .rw_sel(rw_sel), .mosi(mosi), .sclk(sclk)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0]    d;
    int             n;
    logic [CSN-1:0] sel;
  } item_t;
  item_t sb[$];

  // monitor state
  logic prev_sclk, prev_cs, prev_busy, prev_done, same;
  logic [31:0] word;
  logic [CSN-1:0] cs_seen;
  int cyc, nb, t_start, t_csf, t_ff, t_fr, t_csr, t_tail;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 1'b1; prev_cs = 1'b1; prev_busy = 1'b0; prev_done = 1'b0; cyc = 0;
    end else begin
      cyc++;
      if (busy && !prev_busy) begin
        t_start = cyc; nb = 0; word = '0; t_ff = -1; t_fr = -1;
        t_csf = -1; t_csr = -1; t_tail = -1; same = 1'b0; cs_seen = '1;
      end
      if (!(&cs_n) && prev_cs) begin t_csf = cyc; cs_seen = cs_n; end
      if (prev_sclk && !sclk && t_ff < 0) t_ff = cyc;
      if (!prev_sclk && sclk) begin
        if (!(&cs_n)) begin
          word = {word[30:0], mosi}; nb++;
          if (nb == 1) t_fr = cyc;
        end else if (busy) t_tail = cyc;
      end
      if ((&cs_n) && !prev_cs) begin t_csr = cyc; same = prev_sclk && !sclk; end
      if (done && prev_done) chk(1'b0, "R8 done width", 2, 1);
      if (done) begin
        if (sb.size() == 0) chk(1'b0, "R10 unexpected transfer", 1, 0);
        else begin
          item_t it;
          logic [31:0] m;
          it = sb.pop_front();
          m = (it.n == 32) ? 32'hFFFF_FFFF : ((32'd1 << it.n) - 32'd1);
          chk(word == (it.d & m), "R4 word", word, it.d & m);
          chk(nb == it.n, "R4 bit count", nb, it.n);
          chk(cs_seen == ~it.sel, "R2 select line", cs_seen, ~it.sel);
          chk(t_ff - t_csf == D, "R3 setup", t_ff - t_csf, D);
          chk(t_fr - t_ff == 2*D, "R5 low phase", t_fr - t_ff, 2*D);
          chk(same == 1'b1, "R6 release with fall", same, 1);
          chk(t_tail - t_csr == D, "R7 trailing edge", t_tail - t_csr, D);
          chk(cyc - t_start == 3*D*(it.n+1), "R8 busy length", cyc - t_start, 3*D*(it.n+1));
          chk(!busy, "R8 busy low at done", busy, 0);
        end
      end
      prev_sclk = sclk; prev_cs = &cs_n; prev_busy = busy; prev_done = done;
    end
  end

  task automatic xfer(input logic [31:0] d, input int n, input logic [CSN-1:0] sel,
                      input bit intrude);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    data = d; nbits = 6'(n); cs_sel = sel; start = 1'b1;
    it.d = d; it.n = n; it.sel = sel;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(rw_sel == 1'b1, "R2 rw_sel", rw_sel, 1);
    if (intrude) begin
      repeat (5) @(negedge clk);
      data = ~d; nbits = 6'd4; cs_sel = 4'b0001; start = 1'b1;  // R10
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(mosi == d[0], "R11 mosi hold", mosi, d[0]);
    chk(sclk && (&cs_n), "R11 idle pins", {sclk, cs_n}, 5'h1F);
    chk(rw_sel == 1'b1, "R11 rw_sel kept", rw_sel, 1);
  endtask

  task automatic reject(input int n, input logic [CSN-1:0] sel);
    logic m0;
    @(negedge clk);
    while (busy) @(negedge clk);
    m0 = mosi;
    data = 32'hFFFF_FFFF; nbits = 6'(n); cs_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3*D; i++) begin
      if (busy || !sclk || !(&cs_n) || mosi != m0) begin
        chk(1'b0, "R9 reject", {busy, sclk, cs_n}, 6'h1F);
        return;
      end
      @(negedge clk);
    end
    chk(1'b1, "R9 reject", 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(&cs_n, "R1 cs_n", cs_n, 4'hF);
    chk(sclk == 1'b1, "R1 sclk", sclk, 1);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(rw_sel == 1'b0, "R1 rw_sel", rw_sel, 0);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    reject(0, 4'b0001);           // R9 zero count
    xfer(32'h0000_00A5, 8, 4'b0001, 1'b0);
    xfer(32'h0000_0001, 1, 4'b0100, 1'b0);
    xfer(32'hDEAD_BEEF, 32, 4'b1000, 1'b0);
    xfer(32'h0000_0002, 2, 4'b0010, 1'b0);
    reject(33, 4'b0010);          // R9 oversize
    reject(8, 4'b0011);           // R9 two-hot
    reject(8, 4'b0000);           // R9 no select
    xfer(32'h000A_5A5A, 20, 4'b0100, 1'b1);  // R10 start while busy
    repeat (200) @(negedge clk);
    chk(sb.size() == 0, "R10 scoreboard drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule